// File: doc/BRIEF.md
# Sampled Page Tag Cache for Reuse Estimation

This block keeps a small, tag-only picture of the working set seen by a shared last-level cache. It follows a sample of pages and, inside each page, one block out of every eight. Each tracked block carries a presence bit, a pending-write bit and the id of the stream that last wrote or filled it. Because the block keeps its own entries and makes its own replacement choices, the reuse it reports does not depend on how the main cache evicts. Downstream counters can turn these reports into reuse probabilities for each stream.

Each request is a byte address, a read/write flag and a 4-bit stream id. The block classifies the request, updates its own state and, one cycle later, raises at most one of three result kinds:
- a page hit, which may also carry a write-to-read or a read-to-read reuse together with the owning stream,
- an allocation, which may also carry an eviction,
- a bypass.

A stream may add pages only while its allocation count is below its own limit. An epoch pulse clears all contents and all counts. Stream value 10 is normally the dynamic-texture stream, and the requester supplies it; the block treats every id the same way.

The controller has two states. `ST_SWEEP` clears one set per cycle. `ST_RUN` serves requests. Three transitions connect them:
- reset enters `ST_SWEEP` at set 0,
- `ST_SWEEP` moves to `ST_RUN` after it clears the last set,
- `ST_RUN` returns to `ST_SWEEP` when `i_epoch` is high.

Top module: `page_sample_cache`

## Requirements
- R1: Address fields are as follows: block index = addr[11:6]; set = addr[18:12]; page tag = addr[47:19]. A request is sampled only when addr[8:6] == 0, and its slot is then addr[11:9]. A request that is not sampled raises no output and changes no state.
- R2: A sampled request whose page is present but whose slot is empty fills the slot. The slot is marked present, its pending-write bit takes the request's write flag, and its owner becomes the requesting stream. Only `o_page_hit` is raised.
- R3: A read to a present slot with the pending-write bit set raises `o_wr_reuse` and `o_page_hit`, with `o_reuse_sid` equal to the slot owner. It then clears the pending-write bit, so the next read of that slot is a read-to-read reuse.
- R4: A read to a present slot with the pending-write bit clear raises `o_rr_reuse` and `o_page_hit`, with `o_reuse_sid` equal to the slot owner. The owner is unchanged.
- R5: A write to a present slot sets its pending-write bit and makes the writer the owner. It raises only `o_page_hit`.
- R6: On a page miss, if the stream's count is below its limit and the set has an empty way, the lowest-numbered empty way is allocated. `o_alloc` is raised without `o_evict`. The new entry has only the accessed slot present.
- R7: On a page miss, if the stream's count is below its limit and the set is full, a 4-bit LFSR picks the victim way. The LFSR is seeded 4'b0001 at reset, its next value is {s[2:0], s[3]^s[2]}, and it advances after each such replacement. `o_alloc` and `o_evict` are both raised.
- R8: On a page miss where the stream's count is at or above its limit, only `o_bypass` is raised and no state changes.
- R9: Each stream has its own count of page allocations. Stream s uses limit `i_alloc_limit[12*s +: 12]`. Reset and each epoch clear all counts to zero.
- R10: After reset, and after an `i_epoch` pulse taken in `ST_RUN`, the block spends 128 cycles clearing sets. During that time requests are ignored, and afterwards every page misses. The epoch pulse wins over a request in the same cycle.
- R11: Results are registered and appear the cycle after the request. At most one of `o_page_hit`, `o_alloc` and `o_bypass` is high. A reuse implies `o_page_hit`, and `o_evict` implies `o_alloc`. All outputs are zero in reset. `o_reuse_sid` is zero when no reuse is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req_valid | input | 1 | Request present this cycle |
| i_req_addr | input | 48 | Byte address of the request |
| i_req_write | input | 1 | 1 = write, 0 = read |
| i_req_sid | input | 4 | Stream id of the requester |
| i_epoch | input | 1 | Recycle pulse: clears contents and counts |
| i_alloc_limit | input | 192 | Per-stream allocation limits, 12 bits each |
| o_wr_reuse | output | 1 | Write-to-read reuse observed |
| o_rr_reuse | output | 1 | Read-to-read reuse observed |
| o_reuse_sid | output | 4 | Owner stream of the reused slot |
| o_page_hit | output | 1 | Request's page was present |
| o_alloc | output | 1 | A new page entry was written |
| o_evict | output | 1 | The allocation replaced a valid entry |
| o_bypass | output | 1 | Miss not allocated because the stream limit was reached |

## Verification
Every result of a request is registered, so the bench drives the request on a falling edge and compares all outputs 1 ns after the next rising edge. Each comparison is against a reference model that the bench updates in the same step. A recycle lasts 128 cycles after the epoch edge. The bench places one request inside that window and expects every output to be zero. It then waits out the full 128 cycles before the next request and expects that request to miss. Expected LFSR victims and per-stream limits are tracked in the model at the same request granularity, so eviction and bypass are checked in the cycle they are due.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } psc_state_e;

    typedef enum logic [2:0] {
        RES_NONE   = 3'd0,
        RES_FILL   = 3'd1,
        RES_WRITE  = 3'd2,
        RES_WR     = 3'd3,
        RES_RR     = 3'd4,
        RES_ALLOC  = 3'd5,
        RES_EVICT  = 3'd6,
        RES_BYPASS = 3'd7
    } psc_result_e;

endpackage

// File: rtl/psc_addr_split.sv
module psc_addr_split #(
    parameter int ADDR_W  = 48,
    parameter int BLK_W   = 6,
    parameter int PAGE_W  = 12,
    parameter int K_LOG2  = 3,
    parameter int SET_W   = 7,
    parameter int TAG_W   = 29,
    parameter int SLOT_IW = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               sampled,
    output logic [SLOT_IW-1:0] slot,
    output logic [SET_W-1:0]   set_idx,
    output logic [TAG_W-1:0]   tag
);
    logic unused_lo;

    assign unused_lo = ^addr[BLK_W-1:0];
    // only every 2**K_LOG2-th block in the page is tracked
    assign sampled   = (addr[BLK_W +: K_LOG2] == '0);
    assign slot      = addr[BLK_W+K_LOG2 +: SLOT_IW];
    assign set_idx   = addr[PAGE_W +: SET_W];
    assign tag       = addr[PAGE_W+SET_W +: TAG_W];
endmodule

// File: rtl/psc_way_lookup.sv
module psc_way_lookup #(
    parameter int WAYS    = 16,
    parameter int WAY_W   = 4,
    parameter int ENT_W   = 78,
    parameter int TAG_W   = 29,
    parameter int TAG_LSB = 48
) (
    input  logic [WAYS*ENT_W-1:0] row,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       match,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic                  has_free,
    output logic [WAY_W-1:0]      free_way
);
    logic [WAYS-1:0] way_valid;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_valid[w] = row[w*ENT_W + ENT_W - 1];
        assign match[w]     = way_valid[w] && (row[w*ENT_W + TAG_LSB +: TAG_W] == tag);
    end

    assign hit      = |match;
    assign has_free = ~&way_valid;

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])      hit_way  = WAY_W'(w);
            if (!way_valid[w]) free_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/psc_victim_lfsr.sv
module psc_victim_lfsr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [3:0] state
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= 4'b0001;
        else if (step) state <= {state[2:0], state[3] ^ state[2]};
    end

    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != 4'b0000);

    a_r7_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));
endmodule

// File: rtl/psc_pop_gate.sv
module psc_pop_gate #(
    parameter int SID_W   = 4,
    parameter int NSTREAM = 16,
    parameter int POP_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     inc,
    input  logic [SID_W-1:0]         sid,
    input  logic [NSTREAM*POP_W-1:0] limit_flat,
    output logic                     below,
    output logic [POP_W-1:0]         pop_sel
);
    logic [POP_W-1:0] pop [NSTREAM];

    for (genvar s = 0; s < NSTREAM; s++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pop[s] <= '0;
            else if (clear)
                pop[s] <= '0;
            else if (inc && (sid == SID_W'(s)) && (pop[s] != '1))
                pop[s] <= pop[s] + 1'b1;
        end
    end

    assign pop_sel = pop[sid];
    assign below   = pop_sel < limit_flat[sid*POP_W +: POP_W];

    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pop_sel == '0));

    a_r9_no_inc_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |-> below);
endmodule

// File: rtl/page_sample_cache.sv
module page_sample_cache
    import psc_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int SETS   = 128,
    parameter int WAYS   = 16,
    parameter int BLK_W  = 6,
    parameter int PAGE_W = 12,
    parameter int K_LOG2 = 3,
    parameter int SID_W  = 4,
    parameter int POP_W  = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              i_req_valid,
    input  logic [ADDR_W-1:0]                 i_req_addr,
    input  logic                              i_req_write,
    input  logic [SID_W-1:0]                  i_req_sid,
    input  logic                              i_epoch,
    input  logic [(1<<SID_W)*POP_W-1:0]       i_alloc_limit,
    output logic                              o_wr_reuse,
    output logic                              o_rr_reuse,
    output logic [SID_W-1:0]                  o_reuse_sid,
    output logic                              o_page_hit,
    output logic                              o_alloc,
    output logic                              o_evict,
    output logic                              o_bypass
);
    localparam int NSTREAM = 1 << SID_W;
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int TAG_W   = ADDR_W - PAGE_W - SET_W;
    localparam int SLOT_IW = PAGE_W - BLK_W - K_LOG2;
    localparam int SLOTS   = 1 << SLOT_IW;
    localparam int SLOT_W  = 2 + SID_W;          // {sid, pending-write, present}
    localparam int TAG_LSB = SLOTS * SLOT_W;
    localparam int ENT_W   = 1 + TAG_W + TAG_LSB; // {valid, tag, slots}
    localparam int ROW_W   = WAYS * ENT_W;

    // ---------------- request decode ----------------
    logic               samp;
    logic [SLOT_IW-1:0] slot;
    logic [SET_W-1:0]   set_idx;
    logic [TAG_W-1:0]   tag;

    psc_addr_split #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W), .K_LOG2(K_LOG2),
        .SET_W(SET_W), .TAG_W(TAG_W), .SLOT_IW(SLOT_IW)
    ) u_split (
        .addr(i_req_addr), .sampled(samp), .slot(slot),
        .set_idx(set_idx), .tag(tag)
    );

    // ---------------- storage and lookup ----------------
    logic [ROW_W-1:0] mem [SETS];
    logic [ROW_W-1:0] row_rd;
    logic [WAYS-1:0]  match;
    logic             hit, has_free;
    logic [WAY_W-1:0] hit_way, free_way;

    assign row_rd = mem[set_idx];

    psc_way_lookup #(
        .WAYS(WAYS), .WAY_W(WAY_W), .ENT_W(ENT_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)
    ) u_lookup (
        .row(row_rd), .tag(tag), .match(match), .hit(hit), .hit_way(hit_way),
        .has_free(has_free), .free_way(free_way)
    );

    // ---------------- controller state ----------------
    psc_state_e       state, state_nx;
    logic [SET_W-1:0] sweep_idx;
    logic             take_req, epoch_go;

    assign epoch_go = (state == ST_RUN) && i_epoch;
    assign take_req = (state == ST_RUN) && !i_epoch && i_req_valid && samp;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SWEEP: if (sweep_idx == SET_W'(SETS - 1)) state_nx = ST_RUN;
            ST_RUN:   if (i_epoch)                       state_nx = ST_SWEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_SWEEP;
            sweep_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SWEEP) sweep_idx <= sweep_idx + 1'b1;
            else                   sweep_idx <= '0;
        end
    end

    // ---------------- allocation gating and victim choice ----------------
    logic       below, pop_inc, lfsr_step;
    logic [POP_W-1:0] pop_sel;
    logic [3:0] lfsr;

    psc_pop_gate #(.SID_W(SID_W), .NSTREAM(NSTREAM), .POP_W(POP_W)) u_pop (
        .clk(clk), .rst_n(rst_n), .clear(epoch_go), .inc(pop_inc),
        .sid(i_req_sid), .limit_flat(i_alloc_limit), .below(below), .pop_sel(pop_sel)
    );

    psc_victim_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(lfsr_step), .state(lfsr)
    );

    logic unused_pop;
    assign unused_pop = ^pop_sel;

    // ---------------- request decision ----------------
    psc_result_e       res;
    logic              row_we;
    logic [ROW_W-1:0]  row_wr;
    logic [SID_W-1:0]  owner;

    always_comb begin
        logic [ENT_W-1:0]  ent;
        logic [SLOT_W-1:0] sl;
        logic [WAY_W-1:0]  way;
        res       = RES_NONE;
        row_we    = 1'b0;
        row_wr    = row_rd;
        pop_inc   = 1'b0;
        lfsr_step = 1'b0;
        ent       = row_rd[hit_way*ENT_W +: ENT_W];
        sl        = ent[slot*SLOT_W +: SLOT_W];
        owner     = sl[2 +: SID_W];
        way       = hit_way;
        if (take_req) begin
            if (hit) begin
                row_we = 1'b1;
                if (!sl[0]) begin
                    sl  = {i_req_sid, i_req_write, 1'b1};
                    res = RES_FILL;
                end else if (i_req_write) begin
                    sl  = {i_req_sid, 1'b1, 1'b1};
                    res = RES_WRITE;
                end else if (sl[1]) begin
                    sl[1] = 1'b0;
                    res   = RES_WR;
                end else begin
                    res = RES_RR;
                end
                ent[slot*SLOT_W +: SLOT_W] = sl;
            end else if (below) begin
                row_we  = 1'b1;
                pop_inc = 1'b1;
                ent     = '0;
                ent[ENT_W-1] = 1'b1;
                ent[TAG_LSB +: TAG_W] = tag;
                ent[slot*SLOT_W +: SLOT_W] = {i_req_sid, i_req_write, 1'b1};
                if (has_free) begin
                    way = free_way;
                    res = RES_ALLOC;
                end else begin
                    way       = WAY_W'(lfsr);
                    lfsr_step = 1'b1;
                    res       = RES_EVICT;
                end
            end else begin
                res = RES_BYPASS;
            end
            row_wr[way*ENT_W +: ENT_W] = ent;
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_SWEEP) mem[sweep_idx] <= '0;
        else if (row_we)       mem[set_idx]   <= row_wr;
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_wr_reuse  <= 1'b0;
            o_rr_reuse  <= 1'b0;
            o_reuse_sid <= '0;
            o_page_hit  <= 1'b0;
            o_alloc     <= 1'b0;
            o_evict     <= 1'b0;
            o_bypass    <= 1'b0;
        end else begin
            o_wr_reuse  <= 1'b0;
            o_rr_reuse  <= 1'b0;
            o_reuse_sid <= '0;
            o_page_hit  <= 1'b0;
            o_alloc     <= 1'b0;
            o_evict     <= 1'b0;
            o_bypass    <= 1'b0;
            unique case (res)
                RES_NONE:   ;
                RES_FILL:   o_page_hit <= 1'b1;
                RES_WRITE:  o_page_hit <= 1'b1;
                RES_WR: begin
                    o_page_hit  <= 1'b1;
                    o_wr_reuse  <= 1'b1;
                    o_reuse_sid <= owner;
                end
                RES_RR: begin
                    o_page_hit  <= 1'b1;
                    o_rr_reuse  <= 1'b1;
                    o_reuse_sid <= owner;
                end
                RES_ALLOC:  o_alloc <= 1'b1;
                RES_EVICT: begin
                    o_alloc <= 1'b1;
                    o_evict <= 1'b1;
                end
                RES_BYPASS: o_bypass <= 1'b1;
            endcase
        end
    end

    // ---------------- assertions ----------------
    a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_page_hit, o_alloc, o_bypass}));

    a_r11_reuse_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (o_wr_reuse || o_rr_reuse) |-> (o_page_hit && !(o_wr_reuse && o_rr_reuse)));

    a_r7_evict_is_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        o_evict |-> o_alloc);

    a_r10_quiet_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP) |=> !(o_page_hit || o_alloc || o_bypass));

    a_r1_unsampled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req_valid && !samp) |=> !(o_page_hit || o_alloc || o_bypass));

    a_r6_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> $onehot0(match));

    a_r8_bypass_due: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !hit && !below) |=> o_bypass);
endmodule

// File: tb/page_sample_cache_tb.sv
`timescale 1ns/1ps
module page_sample_cache_tb;
    localparam int SETS = 128;
    localparam int WAYS = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld = 1'b0;
    logic [47:0]  addr = '0;
    logic         wr = 1'b0;
    logic [3:0]   sid = '0;
    logic         epoch = 1'b0;
    logic [191:0] limit_bus;
    logic         o_wr, o_rr, o_hit, o_alloc, o_evict, o_byp;
    logic [3:0]   o_sid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model
    bit          m_v  [SETS][WAYS];
    logic [28:0] m_tag[SETS][WAYS];
    bit          m_sv [SETS][WAYS][8];
    bit          m_sw [SETS][WAYS][8];
    logic [3:0]  m_sid[SETS][WAYS][8];
    int          m_pop[16];
    int          lim  [16];
    logic [3:0]  m_lfsr;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) limit_bus[i*12 +: 12] = 12'(lim[i]);
    end

    page_sample_cache u_dut (
        .clk(clk), .rst_n(rst_n), .i_req_valid(vld), .i_req_addr(addr),
        .i_req_write(wr), .i_req_sid(sid), .i_epoch(epoch), .i_alloc_limit(limit_bus),
        .o_wr_reuse(o_wr), .o_rr_reuse(o_rr), .o_reuse_sid(o_sid), .o_page_hit(o_hit),
        .o_alloc(o_alloc), .o_evict(o_evict), .o_bypass(o_byp)
    );

    function automatic logic [9:0] obs();
        return {o_wr, o_rr, o_sid, o_hit, o_alloc, o_evict, o_byp};
    endfunction

    function automatic logic [47:0] mk(logic [28:0] t, int st, int sl, int off);
        return {t, 7'(st), 3'(sl), 3'(off), 6'h15};
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
        for (int i = 0; i < 16; i++) m_pop[i] = 0;
    endtask

    // expected outputs bit order: wr, rr, sid[3:0], page_hit, alloc, evict, bypass
    task automatic predict(logic [47:0] a, bit w, logic [3:0] s,
                           output logic [9:0] e, output string t);
        int st, sl, hw, fw;
        logic [28:0] tg;
        e  = '0;
        st = int'(a[18:12]);
        sl = int'(a[11:9]);
        tg = a[47:19];
        if (a[8:6] != 3'd0) begin t = "R1"; return; end
        hw = -1;
        for (int i = 0; i < WAYS; i++) if (m_v[st][i] && m_tag[st][i] == tg) hw = i;
        if (hw >= 0) begin
            e[3] = 1'b1;
            if (!m_sv[st][hw][sl]) begin
                m_sv[st][hw][sl] = 1; m_sw[st][hw][sl] = w; m_sid[st][hw][sl] = s; t = "R2";
            end else if (w) begin
                m_sw[st][hw][sl] = 1; m_sid[st][hw][sl] = s; t = "R5";
            end else if (m_sw[st][hw][sl]) begin
                m_sw[st][hw][sl] = 0; e[9] = 1'b1; e[7:4] = m_sid[st][hw][sl]; t = "R3";
            end else begin
                e[8] = 1'b1; e[7:4] = m_sid[st][hw][sl]; t = "R4";
            end
        end else if (m_pop[s] < lim[s]) begin
            fw = -1;
            for (int i = WAYS - 1; i >= 0; i--) if (!m_v[st][i]) fw = i;
            e[2] = 1'b1;
            if (fw >= 0) t = "R6";
            else begin
                fw = int'(m_lfsr);
                m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
                e[1] = 1'b1;
                t = "R7";
            end
            m_v[st][fw] = 1; m_tag[st][fw] = tg;
            for (int k = 0; k < 8; k++) begin m_sv[st][fw][k] = 0; m_sw[st][fw][k] = 0; end
            m_sv[st][fw][sl] = 1; m_sw[st][fw][sl] = w; m_sid[st][fw][sl] = s;
            if (m_pop[s] < 4095) m_pop[s]++;
        end else begin
            e[0] = 1'b1; t = "R8";
        end
    endtask

    task automatic do_req(logic [47:0] a, bit w, logic [3:0] s, string req);
        logic [9:0] e;
        string t;
        @(negedge clk);
        addr = a; wr = w; sid = s; vld = 1'b1;
        predict(a, w, s, e, t);
        @(posedge clk); #1;
        check(req == "" ? t : req, obs(), e);
        vld = 1'b0;
    endtask

    task automatic do_quiet(logic [47:0] a, string req);
        @(negedge clk);
        addr = a; wr = 1'b0; sid = 4'd1; vld = 1'b1;
        @(posedge clk); #1;
        check(req, obs(), 10'b0);
        vld = 1'b0;
    endtask

    task automatic do_epoch();
        @(negedge clk); epoch = 1'b1;
        @(posedge clk); #1; epoch = 1'b0;
        model_clear();
        do_quiet(mk(29'h1, 3, 0, 0), "R10 sweep ignores request");
        repeat (SETS + 2) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) lim[i] = 4000;
        model_clear();
        m_lfsr = 4'b0001;
        repeat (3) @(posedge clk);
        #1 check("R11 reset outputs", obs(), 10'b0);
        @(negedge clk); rst_n = 1'b1;
        do_quiet(mk(29'h2, 3, 0, 0), "R10 reset sweep ignores request");
        repeat (SETS + 2) @(posedge clk);

        // directed cases
        do_req(mk(29'hA, 3, 2, 4), 0, 4'd1, "R1 unsampled ignored");
        do_req(mk(29'hA, 3, 2, 0), 0, 4'd1, "R1 page not created by unsampled; R6 lowest free");
        do_req(mk(29'hA, 3, 2, 0), 0, 4'd3, "R4 read-read owner kept");
        do_req(mk(29'hA, 3, 5, 0), 0, 4'd1, "R2 slot fill");
        do_req(mk(29'hA, 3, 5, 0), 1, 4'd7, "R5 write hit");
        do_req(mk(29'hA, 3, 5, 0), 0, 4'd2, "R3 write-read reuse");
        do_req(mk(29'hA, 3, 5, 0), 0, 4'd2, "R3 pending cleared");
        do_req(mk(29'hA, 3, 6, 0), 1, 4'd9, "R2 fill by write");
        do_req(mk(29'hA, 3, 6, 0), 0, 4'd1, "R3 reuse after write fill");
        for (int i = 1; i < WAYS; i++) do_req(mk(29'h100 + 29'(i), 3, 0, 0), 0, 4'd1, "R6 fill set");
        do_req(mk(29'hC, 3, 1, 0), 0, 4'd1, "R7 random victim");
        do_req(mk(29'h101, 3, 0, 0), 0, 4'd1, "R7 evicted page misses");
        do_req(mk(29'hA, 3, 2, 0), 0, 4'd1, "R7 unaffected way still hits");

        do_epoch();
        do_req(mk(29'hA, 3, 2, 0), 0, 4'd1, "R10 miss after recycle");
        lim[5] = 2;
        do_req(mk(29'h20, 10, 0, 0), 0, 4'd5, "R9 count 0");
        do_req(mk(29'h21, 11, 0, 0), 0, 4'd5, "R9 count 1");
        do_req(mk(29'h22, 12, 0, 0), 0, 4'd5, "R8 limit reached");
        do_req(mk(29'h22, 12, 0, 0), 0, 4'd6, "R9 other stream allocates; R8 no state left");
        do_req(mk(29'h23, 12, 0, 0), 0, 4'd5, "R8 still bypass");
        do_epoch();
        do_req(mk(29'h24, 13, 0, 0), 0, 4'd5, "R9 count cleared by epoch");

        // constrained random phase
        begin
            int unused_seed;
            unused_seed = $urandom(32'd20240611);
        end
        for (int i = 0; i < 16; i++) lim[i] = 3 + int'($urandom_range(0, 17));
        for (int n = 0; n < 3000; n++) begin
            logic [28:0] t;
            int st, sl, off;
            bit w;
            logic [3:0] s;
            t   = 29'($urandom_range(0, 23));
            st  = int'($urandom_range(0, 3));
            sl  = int'($urandom_range(0, 7));
            off = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 7)) : 0;
            w   = ($urandom_range(0, 9) < 3);
            s   = 4'($urandom_range(0, 15));
            do_req(mk(t, st, sl, off), w, s, "");
            if ((n % 700) == 699) do_epoch();
        end

        finished = 1;
        finish_run();
    end
endmodule